// File: doc/BRIEF.md
# Signed Multiply-Accumulate Unit with Rounding Right Shift

This unit takes an accumulator word and two signed multiplicands, forms their full-width signed product and either adds it to or subtracts it from the accumulator. A 5-bit shift amount then picks between two result modes. With a zero shift the result is the plain XLEN-bit sum or difference, which wraps on overflow. With a nonzero shift the accumulation is done at double width, a half-unit rounding constant is added, and a window of XLEN bits is taken from the shifted sum.

The main use is to finish a two-coefficient butterfly. First a twin step runs with a zero shift and produces `a*c1 + b*c1` and `a*c1 - b*c1`. Then this unit adds `b*(c2-c1)` to the first value and subtracts it from the second, both with the final rounding shift. The first result becomes the rounded form of `a*c1 + b*c2` and the second the rounded form of `a*c1 - b*c2`. Every valid input yields one registered result one clock later.

Top module: `mac_round_unit`

## Requirements
- R1: While `rst_n` is low, `out_valid` is 0 and `out_result` is all zeros.
- R2: The product is the full 2*XLEN-bit two's-complement product of `in_mula` and `in_mulb`. No product bit is lost before the shifted window is taken.
- R3: With `in_shamt` = 0 and `in_sub` = 0 (add), the result is `in_acc` plus the low XLEN bits of the product, taken modulo 2^XLEN.
- R4: With `in_shamt` = 0 and `in_sub` = 1 (subtract), the result is `in_acc` minus the low XLEN bits of the product, taken modulo 2^XLEN.
- R5: With `in_shamt` = n > 0, `in_acc` is sign-extended to 2*XLEN bits and the product is added (`in_sub` = 0) or subtracted (`in_sub` = 1) modulo 2^(2*XLEN). Then 2^(n-1) is added, and the result is bits n to n+XLEN-1 of that sum.
- R6: The rounding constant is always added, whichever way the product is applied. A value exactly halfway between two steps rounds toward plus infinity in both modes: for example, -3 shifted by 1 gives -1.
- R7: `in_shamt` is 5 bits wide, and every value from 1 to 31 follows R5, including the largest, 31.
- R8: `out_valid` is high in the cycle after an `in_valid` cycle and low in the cycle after an idle cycle. `out_result` carries the result of the input accepted on that edge.
- R9: When `in_valid` is low, the operand inputs have no effect and `out_result` keeps its previous value.
- R10: Start from a twin step with a zero shift (`(a+b)*c1` and `(a-b)*c1`). Adding `b*(c2-c1)` to the first with shift 14 gives `(a*c1 + b*c2 + 2^13) >> 14`. Subtracting it from the second with shift 14 gives `(a*c1 - b*c2 + 2^13) >> 14`. Both use an arithmetic shift.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Accept the operands on this edge |
| in_acc | input | XLEN | Accumulator operand, signed |
| in_mula | input | XLEN | First multiplicand, signed |
| in_mulb | input | XLEN | Second multiplicand, signed |
| in_sub | input | 1 | 0 adds the product, 1 subtracts it |
| in_shamt | input | SHW | Rounding shift amount; 0 selects the wrapping narrow mode |
| out_valid | output | 1 | Result valid, one cycle after `in_valid` |
| out_result | output | XLEN | Registered result |

## Verification
The datapath is combinational up to a single output register. Any operand set driven with `in_valid` high therefore appears on `out_result`, with `out_valid` high, after exactly one rising edge. The bench drives inputs on the falling edge and samples the outputs on the next falling edge, half a period after the capturing edge. It then spends one idle cycle with scrambled operands and checks, at the following falling edge, that `out_valid` has dropped and the result has held. The two-coefficient chains run as two separate single-cycle operations, and each result is compared on its own due cycle against the direct computation.

// File: rtl/mac_round_pkg.sv
package mac_round_pkg;

  // Direction in which the product is applied to the accumulator.
  typedef enum logic {
    MAC_ADD = 1'b0,
    MAC_SUB = 1'b1
  } mac_dir_e;

endpackage

// File: rtl/mac_product.sv
module mac_product #(
  parameter int XLEN = 32,
  localparam int PW  = 2 * XLEN
) (
  input  logic [XLEN-1:0] mula,
  input  logic [XLEN-1:0] mulb,
  output logic [PW-1:0]   prod
);

  // Sign-extend both operands to the product width. The low PW bits of
  // their product are then the exact signed product.
  function automatic logic [PW-1:0] sext_to_pw(input logic [XLEN-1:0] v);
    return {{XLEN{v[XLEN-1]}}, v};
  endfunction

  function automatic logic [PW-1:0] full_mul(input logic [XLEN-1:0] x,
                                             input logic [XLEN-1:0] y);
    return sext_to_pw(x) * sext_to_pw(y);
  endfunction

  assign prod = full_mul(mula, mulb);

endmodule

// File: rtl/mac_combine.sv
module mac_combine
  import mac_round_pkg::*;
#(
  parameter int XLEN = 32,
  parameter int SHW  = 5,
  localparam int PW  = 2 * XLEN
) (
  input  logic [XLEN-1:0] acc,
  input  logic [PW-1:0]   prod,
  input  mac_dir_e        dir,
  input  logic [SHW-1:0]  shamt,
  output logic [XLEN-1:0] result,
  output logic [XLEN-1:0] wrap_res,
  output logic [XLEN-1:0] mix_lo
);

  logic [PW-1:0]   acc_wide;
  logic [PW-1:0]   mix_wide;
  logic [PW-1:0]   rnd_const;
  logic [PW-1:0]   rounded;
  logic [PW-1:0]   shifted;
  logic            shift_on;

  // Narrow mode: wrap at XLEN bits, only the low product half matters.
  function automatic logic [XLEN-1:0] narrow_mix(input logic [XLEN-1:0] a,
                                                 input logic [XLEN-1:0] p,
                                                 input mac_dir_e d);
    return (d == MAC_SUB) ? (a - p) : (a + p);
  endfunction

  // Wide mode: accumulate at the full product width.
  function automatic logic [PW-1:0] wide_mix(input logic [PW-1:0] a,
                                             input logic [PW-1:0] p,
                                             input mac_dir_e d);
    return (d == MAC_SUB) ? (a - p) : (a + p);
  endfunction

  // Half of one output step at shift n, i.e. 2^(n-1); zero when n is 0.
  function automatic logic [PW-1:0] half_step(input logic [SHW-1:0] n);
    logic [PW-1:0] r;
    r = '0;
    if (n != '0) r = PW'(1) << (n - SHW'(1));
    return r;
  endfunction

  assign shift_on  = (shamt != '0);
  assign acc_wide  = {{XLEN{acc[XLEN-1]}}, acc};
  assign mix_wide  = wide_mix(acc_wide, prod, dir);
  assign rnd_const = half_step(shamt);
  assign rounded   = mix_wide + rnd_const;
  assign shifted   = rounded >> shamt;
  assign wrap_res  = narrow_mix(acc, prod[XLEN-1:0], dir);
  assign mix_lo    = mix_wide[XLEN-1:0];
  assign result    = shift_on ? shifted[XLEN-1:0] : wrap_res;

endmodule

// File: rtl/mac_round_unit.sv
module mac_round_unit
  import mac_round_pkg::*;
#(
  parameter int XLEN = 32,
  parameter int SHW  = 5
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            in_valid,
  input  logic [XLEN-1:0] in_acc,
  input  logic [XLEN-1:0] in_mula,
  input  logic [XLEN-1:0] in_mulb,
  input  logic            in_sub,
  input  logic [SHW-1:0]  in_shamt,
  output logic            out_valid,
  output logic [XLEN-1:0] out_result
);

  localparam int PW = 2 * XLEN;

  logic [PW-1:0]   prod_full;
  logic [XLEN-1:0] next_result;
  logic [XLEN-1:0] wrap_res;
  logic [XLEN-1:0] mix_lo;
  mac_dir_e        dir;

  assign dir = mac_dir_e'(in_sub);

  mac_product #(.XLEN(XLEN)) prod_i (
    .mula (in_mula),
    .mulb (in_mulb),
    .prod (prod_full)
  );

  mac_combine #(.XLEN(XLEN), .SHW(SHW)) comb_i (
    .acc      (in_acc),
    .prod     (prod_full),
    .dir      (dir),
    .shamt    (in_shamt),
    .result   (next_result),
    .wrap_res (wrap_res),
    .mix_lo   (mix_lo)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid  <= 1'b0;
      out_result <= '0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) out_result <= next_result;
    end
  end

  // R8
  valid_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);

  // R8
  valid_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !out_valid);

  // R9
  result_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> $stable(out_result));

  // R2
  zero_prod_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && (in_mula == '0 || in_mulb == '0)) |-> (prod_full == '0));

  // R3
  wrap_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_shamt == '0) |-> (mix_lo == wrap_res));

  // R5
  shifted_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> (out_result == $past(next_result)));

endmodule

// File: tb/mac_round_unit_tb.sv
`timescale 1ns/1ps
module mac_round_unit_tb_top;

  localparam int XLEN = 32;
  localparam int SHW  = 5;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic            in_valid = 1'b0;
  logic [XLEN-1:0] in_acc = '0;
  logic [XLEN-1:0] in_mula = '0;
  logic [XLEN-1:0] in_mulb = '0;
  logic            in_sub = 1'b0;
  logic [SHW-1:0]  in_shamt = '0;
  logic            out_valid;
  logic [XLEN-1:0] out_result;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 1'b0;

  always #4 clk = ~clk;

  mac_round_unit #(.XLEN(XLEN), .SHW(SHW)) dut_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .in_valid   (in_valid),
    .in_acc     (in_acc),
    .in_mula    (in_mula),
    .in_mulb    (in_mulb),
    .in_sub     (in_sub),
    .in_shamt   (in_shamt),
    .out_valid  (out_valid),
    .out_result (out_result)
  );

  // Expected value restated with 64-bit integer arithmetic.
  function automatic logic [31:0] model(input logic [31:0] acc,
                                        input logic [31:0] a,
                                        input logic [31:0] b,
                                        input bit sub, input int n);
    longint p, x, s;
    logic [63:0] pb;
    p  = longint'($signed(a)) * longint'($signed(b));
    x  = longint'($signed(acc));
    pb = p;
    if (n == 0) return sub ? (acc - pb[31:0]) : (acc + pb[31:0]);
    s = sub ? (x - p) : (x + p);
    s = s + (longint'(1) <<< (n - 1));
    s = s >>> n;
    return s[31:0];
  endfunction

  function automatic logic [31:0] direct_rs(input longint v);
    longint s;
    s = (v + 64'sd8192) >>> 14;
    return s[31:0];
  endfunction

  task automatic check(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  // One accepted operation, its due-cycle sample, then an idle cycle.
  task automatic run_op(input string req, input logic [31:0] acc,
                        input logic [31:0] a, input logic [31:0] b,
                        input bit sub, input int n,
                        output logic [31:0] res);
    logic [31:0] exp;
    exp      = model(acc, a, b, sub, n);
    in_acc   = acc;
    in_mula  = a;
    in_mulb  = b;
    in_sub   = sub;
    in_shamt = SHW'(n);
    in_valid = 1'b1;
    @(negedge clk);
    check("R8", "valid after op", {31'd0, out_valid}, 32'd1);
    check(req, "result", out_result, exp);
    res = out_result;
    in_valid = 1'b0;
    in_acc   = $urandom;
    in_mula  = $urandom;
    in_mulb  = $urandom;
    in_sub   = 1'($urandom);
    in_shamt = SHW'($urandom);
    @(negedge clk);
    check("R8", "valid idle", {31'd0, out_valid}, 32'd0);
    check("R9", "hold while idle", out_result, res);
  endtask

  initial begin
    #(8 * 150000);
    n_checks++;
    n_fail++;
    $display("FAIL R8 watchdog actual=hung expected=done");
    if (!done) begin
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end

  initial begin
    logic [31:0] r;
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    // R1 reset state
    check("R1", "reset valid", {31'd0, out_valid}, 32'd0);
    check("R1", "reset result", out_result, 32'd0);
    rst_n = 1'b1;
    @(negedge clk);

    // R3 overflow wraps at XLEN bits
    run_op("R3", 32'h7fffffff, 32'd1, 32'd1, 1'b0, 0, r);
    check("R3", "wrap to min", r, 32'h80000000);
    run_op("R3", 32'h00001234, 32'h00010000, 32'h00010000, 1'b0, 0, r);
    check("R3", "high product half dropped", r, 32'h00001234);
    // R4 subtract wraps
    run_op("R4", 32'h80000000, 32'd1, 32'd1, 1'b1, 0, r);
    check("R4", "wrap to max", r, 32'h7fffffff);
    // R6 half rounds up in both directions
    run_op("R6", 32'd0, 32'd3, 32'd1, 1'b1, 1, r);
    check("R6", "sub -3>>1", r, 32'hffffffff);
    run_op("R6", 32'd0, 32'hfffffffd, 32'd1, 1'b0, 1, r);
    check("R6", "add -3>>1", r, 32'hffffffff);
    run_op("R6", 32'd0, 32'd3, 32'd1, 1'b0, 1, r);
    check("R6", "add 3>>1", r, 32'd2);
    // R2 R7 extreme product at the largest shift
    run_op("R2", 32'd0, 32'h80000000, 32'h80000000, 1'b0, 31, r);
    check("R7", "shift 31 min*min", r, 32'h80000000);
    run_op("R7", 32'h7fffffff, 32'h7fffffff, 32'h80000000, 1'b1, 31, r);
    // R5 wide accumulation with sign-extended accumulator
    run_op("R5", 32'hffffffff, 32'h40000000, 32'h00000004, 1'b0, 16, r);
    check("R5", "wide carry kept", r, 32'h00010000);

    // R5 R2 random mix across all modes
    for (int i = 0; i < 300; i++) begin
      int n;
      n = (i % 4 == 0) ? 0 : int'($urandom_range(0, 31));
      run_op(n == 0 ? "R3" : "R5", $urandom, $urandom, $urandom,
             1'($urandom), n, r);
    end

    // R10 double-coefficient butterfly chains, 16-bit range inputs
    for (int i = 0; i < 60; i++) begin
      int a, b, c1, c2;
      logic [31:0] t0, t1;
      a  = int'($urandom_range(0, 65535)) - 32768;
      b  = int'($urandom_range(0, 65535)) - 32768;
      c1 = int'($urandom_range(0, 32767)) - 16384;
      c2 = int'($urandom_range(0, 32767)) - 16384;
      t0 = 32'((a + b) * c1);
      t1 = 32'((a - b) * c1);
      run_op("R10", t0, 32'(b), 32'(c2 - c1), 1'b0, 14, r);
      check("R10", "sum branch",
            r, direct_rs(longint'(a) * c1 + longint'(b) * c2));
      run_op("R10", t1, 32'(b), 32'(c2 - c1), 1'b1, 14, r);
      check("R10", "diff branch",
            r, direct_rs(longint'(a) * c1 - longint'(b) * c2));
    end

    done = 1'b1;
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

endmodule